// File: doc/BRIEF.md
# One-Hot Ring Sequencer with Upset Parity Guard

This block is an eight-position ring sequencer held in one flip-flop per position. In normal operation exactly one bit of the state vector is 1. Each clock edge with the advance input high moves that bit one place toward bit 0, and bit 0 wraps back to the top bit. Out of the 256 codes the register can hold, only 8 are legal. A corrupted register can therefore land in a code that the shift logic alone never leaves.

A parity monitor reads the register every cycle and raises an error whenever the vector holds an even number of ones. Any single flipped bit produces such a vector. The error also sets a sticky flag, and only reset clears that flag. When the recovery input is high, an error forces the register back to the home code on the next edge. When recovery is low, a damaged pattern keeps rotating as it is.

A flip mask is XORed into the next state on every edge, so upsets can be injected on purpose. Two flips that leave an odd count of ones cannot be seen by the parity monitor.

Top module: `ring_seq_guard`

## Requirements
- R1: While rst is high at a clock edge, the state becomes home, which is bit 7 alone (8'h80). After a reset edge, err_o and err_sticky_o read 0.
- R2: When adv_en is 1, flip_mask is 0 and no recovery applies, each edge moves every bit of state_o one position toward bit 0. Bit 0 wraps into bit 7, so 8'h80 goes to 8'h40 and 8'h01 goes to 8'h80.
- R3: When adv_en is 0, flip_mask is 0 and no recovery applies, state_o keeps its value across the edge.
- R4: err_o is 1 in the same cycle whenever state_o holds an even number of ones, including zero ones. It is 0 whenever the count is odd.
- R5: Each 1 bit of flip_mask inverts the matching bit of the value that would otherwise be loaded at that edge. That value is the rotated state when advancing, or the held state when not.
- R6: When recov_en and err_o are both 1 at an edge, state_o becomes 8'h80 at that edge. This takes priority over adv_en and flip_mask.
- R7: With recov_en at 0, a corrupted vector is never repaired. A two-ones pattern keeps rotating with both bits, err_o stays 1, and after 8 advances the pattern returns to itself.
- R8: err_sticky_o becomes 1 at the edge after a cycle in which err_o is 1. It stays 1 until a reset edge, even after the state has been repaired.
- R9: A flip_mask with two bits set that leaves an odd number of ones is not flagged. err_o and err_sticky_o stay 0, and recovery does not restore the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to home |
| adv_en | input | 1 | Advance the ring by one position at this edge |
| recov_en | input | 1 | Return to home on a parity error |
| flip_mask | input | 8 | Bits to invert in the next state (upset injection) |
| state_o | output | 8 | State register |
| err_o | output | 1 | Even parity seen on the current state |
| err_sticky_o | output | 1 | Latched error, cleared only by reset |

## Verification
On every cycle, the assertions check the rotation and hold steps, the home load after reset or recovery, the tie between the count of ones and the error flag, and the way the sticky flag sets and stays set. Only the bench's scenarios can show the properties that span a sequence of edges. These are a two-bit pattern circulating for a full turn without repair, the sticky flag outliving a repair until the next reset, and a two-bit injection that keeps odd parity passing unnoticed even with recovery enabled.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;
    // Ring length in positions (one flip-flop each)
    parameter int unsigned RING_W = 8;

    // Source of the next state value
    typedef enum logic [1:0] {
        NS_KEEP = 2'd0,
        NS_STEP = 2'd1,
        NS_HOME = 2'd2
    } ns_sel_e;

    // Control inputs seen by the next-state logic in one cycle
    typedef struct packed {
        logic adv;
        logic recov;
        logic err;
    } ring_ctrl_t;
endpackage

// File: rtl/ring_parity_mon.sv
module ring_parity_mon #(
    parameter int unsigned W = ring_seq_pkg::RING_W
) (
    input  logic [W-1:0] vec_i,
    output logic         err_o
);
    // A legal code has a single one, so odd parity; even parity is an upset
    always_comb begin
        err_o = ~(^vec_i);
    end
endmodule

// File: rtl/ring_step_logic.sv
module ring_step_logic
    import ring_seq_pkg::*;
#(
    parameter int unsigned W = RING_W
) (
    input  logic [W-1:0] cur_i,
    input  ring_ctrl_t   ctrl_i,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] nxt_o
);
    localparam int unsigned HOME_BIT = W - 1;
    localparam logic [W-1:0] HOME_VEC = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] rot;
    ns_sel_e      sel;

    // Each position takes its upper neighbour; the top one takes bit 0
    for (genvar i = 0; i < W; i++) begin : g_rot
        if (i == HOME_BIT) begin : g_wrap
            assign rot[i] = cur_i[0];
        end else begin : g_shift
            assign rot[i] = cur_i[i+1];
        end
    end

    always_comb begin
        if (ctrl_i.recov && ctrl_i.err) begin
            sel = NS_HOME;
        end else if (ctrl_i.adv) begin
            sel = NS_STEP;
        end else begin
            sel = NS_KEEP;
        end
    end

    always_comb begin
        unique case (sel)
            NS_HOME: nxt_o = HOME_VEC;
            NS_STEP: nxt_o = rot ^ flip_i;
            default: nxt_o = cur_i ^ flip_i;
        endcase
    end
endmodule

// File: rtl/ring_sticky_flag.sv
module ring_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ring_seq_guard.sv
module ring_seq_guard
    import ring_seq_pkg::*;
#(
    parameter int unsigned W = RING_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_en,
    input  logic         recov_en,
    input  logic [W-1:0] flip_mask,
    output logic [W-1:0] state_o,
    output logic         err_o,
    output logic         err_sticky_o
);
    localparam logic [W-1:0] HOME_VEC = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    logic         par_err;
    ring_ctrl_t   ctrl;

    ring_parity_mon #(.W(W)) u_par (
        .vec_i (state_q),
        .err_o (par_err)
    );

    always_comb begin
        ctrl.adv   = adv_en;
        ctrl.recov = recov_en;
        ctrl.err   = par_err;
    end

    ring_step_logic #(.W(W)) u_step (
        .cur_i  (state_q),
        .ctrl_i (ctrl),
        .flip_i (flip_mask),
        .nxt_o  (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOME_VEC;
        end else begin
            state_q <= state_d;
        end
    end

    ring_sticky_flag u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_i  (par_err),
        .flag_o (err_sticky_o)
    );

    assign state_o = state_q;
    assign err_o   = par_err;
endmodule

// File: rtl/ring_seq_guard_chk.sv
module ring_seq_guard_chk #(
    parameter int unsigned W = ring_seq_pkg::RING_W
) (
    input logic         clk,
    input logic         rst,
    input logic         adv_en,
    input logic         recov_en,
    input logic [W-1:0] flip_mask,
    input logic [W-1:0] state_o,
    input logic         err_o,
    input logic         err_sticky_o
);
    localparam logic [W-1:0] HOME_VEC = {1'b1, {(W-1){1'b0}}};

    logic fix_now;
    assign fix_now = recov_en && err_o;

    // R1: a reset edge leaves home and a clear sticky flag
    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (state_o == HOME_VEC && !err_sticky_o));

    // R2: a plain advance rotates toward bit 0 with wrap
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !fix_now && flip_mask == '0)
        |=> state_o == {$past(state_o[0]), $past(state_o[W-1:1])});

    // R3: no advance, no flips, no recovery keeps the state
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!adv_en && !fix_now && flip_mask == '0) |=> $stable(state_o));

    // R4: error flag follows the count of ones
    p_odd_clean_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(state_o) % 2 == 1) |-> !err_o);
    p_even_flag_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(state_o) % 2 == 0) |-> err_o);

    // R6: recovery loads home at the next edge
    p_recover_r6: assert property (@(posedge clk) disable iff (rst)
        fix_now |=> state_o == HOME_VEC);

    // R8: sticky flag sets after an error and then holds
    p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_sticky_o);
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
        err_sticky_o |=> err_sticky_o);
endmodule

bind ring_seq_guard ring_seq_guard_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adv_en       (adv_en),
    .recov_en     (recov_en),
    .flip_mask    (flip_mask),
    .state_o      (state_o),
    .err_o        (err_o),
    .err_sticky_o (err_sticky_o)
);

// File: tb/ring_seq_guard_test.sv
module ring_seq_guard_test;
    localparam int unsigned W = 8;
    localparam logic [W-1:0] HOME = 8'h80;

    logic         clk = 1'b0;
    logic         rst;
    logic         adv_en;
    logic         recov_en;
    logic [W-1:0] flip_mask;
    logic [W-1:0] state_o;
    logic         err_o;
    logic         err_sticky_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ring_seq_guard #(.W(W)) uut (
        .clk          (clk),
        .rst          (rst),
        .adv_en       (adv_en),
        .recov_en     (recov_en),
        .flip_mask    (flip_mask),
        .state_o      (state_o),
        .err_o        (err_o),
        .err_sticky_o (err_sticky_o)
    );

    function automatic logic [W-1:0] rotr(input logic [W-1:0] v);
        return {v[0], v[W-1:1]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [W-1:0] exp);
        chk(state_o === exp, req, "state", state_o, exp);
    endtask

    task automatic chk_err(input string req, input logic exp);
        chk(err_o === exp, req, "err", {7'd0, err_o}, {7'd0, exp});
    endtask

    task automatic chk_sticky(input string req, input logic exp);
        chk(err_sticky_o === exp, req, "sticky", {7'd0, err_sticky_o}, {7'd0, exp});
    endtask

    // one clock edge; inputs change and outputs are sampled 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; adv_en = 1'b0; recov_en = 1'b0; flip_mask = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_state("R1", HOME);
        chk_err("R1", 1'b0);
        chk_sticky("R1", 1'b0);
    endtask

    task automatic t_advance();
        logic [W-1:0] exp;
        do_reset();
        exp = HOME;
        adv_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            exp = rotr(exp);
            chk_state("R2", exp);
            chk_err("R4", 1'b0);
        end
        chk_state("R2", 8'h20);
    endtask

    task automatic t_hold();
        logic [W-1:0] held;
        do_reset();
        adv_en = 1'b1; step(); step();
        held = state_o;
        adv_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk_state("R3", held);
        end
        chk_state("R3", 8'h20);
    endtask

    task automatic t_lockup();
        logic [W-1:0] exp;
        do_reset();
        adv_en = 1'b1; flip_mask = 8'h08;
        step();
        flip_mask = '0;
        chk_state("R5", 8'h48);
        chk_err("R4", 1'b1);
        chk_sticky("R8", 1'b0);
        exp = 8'h48;
        for (int i = 0; i < 8; i++) begin
            step();
            exp = rotr(exp);
            chk_state("R7", exp);
            chk_err("R7", 1'b1);
        end
        chk_state("R7", 8'h48);
        chk_sticky("R8", 1'b1);
    endtask

    task automatic t_zero();
        do_reset();
        adv_en = 1'b0; flip_mask = 8'h80;
        step();
        flip_mask = '0;
        chk_state("R5", 8'h00);
        chk_err("R4", 1'b1);
        adv_en = 1'b1;
        step(); step();
        chk_state("R7", 8'h00);
        chk_err("R7", 1'b1);
    endtask

    task automatic t_recover();
        do_reset();
        recov_en = 1'b1; adv_en = 1'b1; flip_mask = 8'h01;
        step();
        flip_mask = 8'h10;
        chk_state("R5", 8'h41);
        chk_err("R4", 1'b1);
        step();
        flip_mask = '0;
        chk_state("R6", HOME);
        chk_err("R6", 1'b0);
        chk_sticky("R8", 1'b1);
        step(); step();
        chk_state("R2", 8'h20);
        chk_sticky("R8", 1'b1);
        rst = 1'b1; step(); rst = 1'b0;
        chk_sticky("R8", 1'b0);
        chk_state("R1", HOME);
    endtask

    task automatic t_hidden_double();
        do_reset();
        recov_en = 1'b1; adv_en = 1'b0; flip_mask = 8'h03;
        step();
        flip_mask = '0;
        chk_state("R9", 8'h83);
        chk_err("R9", 1'b0);
        step(); step();
        chk_state("R9", 8'h83);
        chk_sticky("R9", 1'b0);
        do_reset();
        recov_en = 1'b1; adv_en = 1'b1; flip_mask = 8'h41;
        step();
        flip_mask = '0;
        chk_state("R9", 8'h01);
        chk_err("R9", 1'b0);
        step();
        chk_state("R9", HOME);
        chk_sticky("R9", 1'b0);
    endtask

    initial begin
        rst = 1'b1; adv_en = 1'b0; recov_en = 1'b0; flip_mask = '0;
        t_reset();
        t_advance();
        t_hold();
        t_lockup();
        t_zero();
        t_recover();
        t_hidden_double();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule